// File: doc/BRIEF.md
# Cascaded Configuration Receiver

This block is the receiving end of configuration in one device of a cascaded chain. While its active-low enable input is high it ignores the data bus. Once the enable is low it takes configuration data on each rising edge of its configuration clock. In parallel mode it takes a whole byte per edge. In serial mode it takes one bit per edge from data line 0 and packs the bits into bytes, least significant bit first. Each finished byte is presented on a byte output with a one-cycle valid strobe.

When the programmed length has arrived, the block drives its active-low hand-off output low. That output feeds the enable of the next device in the chain. At the same edge the block stops pulling its open-drain done line low. It enters user mode only when the wired done line, shared by every device, reads high, so all devices start together.

An open-drain status line is shared by the whole chain. If the enable input is withdrawn in the middle of a load, the block pulls the status line low for one cycle. Whenever the wired status reads low outside user mode, the block returns to its idle state and waits for a fresh load. Each open-drain signal has a drive output (high means pull low) and a separate input that returns the wired value.

Top module: `cfg_chain_rx`

## Requirements
- R1: After a synchronous reset: chain_en_n = 1, done_pull = 1, status_pull = 0, user_mode = 0, byte_valid = 0.
- R2: While chip_en_n is high before a load has started, data_in is ignored. byte_valid stays 0 and chain_en_n stays 1.
- R3: In serial mode (par_mode = 0), each captured edge takes only data_in[0]. Bit k of a byte is the k-th bit received, counting from 0. byte_valid is 1 for one cycle after every 8th bit, with the assembled byte on byte_out.
- R4: In parallel mode (par_mode = 1), each captured edge takes all of data_in. The next cycle shows byte_valid = 1 and byte_out equal to the captured value.
- R5: chain_en_n goes low one cycle after the last unit of the load is captured, and not earlier. The load is CFG_BITS bits in serial mode and CFG_BITS/8 bytes in parallel mode. chain_en_n then stays low until a restart.
- R6: done_pull is 1 for the whole load. It changes to 0 in the same cycle that chain_en_n goes low, and chain_en_n is never low while done_pull is 1.
- R7: After release, user_mode stays 0 while done_wired is low. user_mode becomes 1 one cycle after done_wired is sampled high.
- R8: If chip_en_n goes high during a load, status_pull is 1 for exactly one cycle.
- R9: When status_wired is sampled low outside user mode, the next cycle shows chain_en_n = 1, done_pull = 1, status_pull = 0. The length count then starts again from zero.
- R10: In user mode, data_in, chip_en_n and status_wired have no effect: byte_valid stays 0 and user_mode stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; data is captured on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| par_mode | input | 1 | 1 = one byte per clock, 0 = one bit per clock on data line 0 |
| chip_en_n | input | 1 | Active-low enable from the previous device or the controller |
| data_in | input | DATA_W | Configuration data bus |
| done_wired | input | 1 | Resolved value of the shared done line |
| status_wired | input | 1 | Resolved value of the shared status line |
| chain_en_n | output | 1 | Active-low enable handed to the next device |
| done_pull | output | 1 | 1 pulls the shared done line low |
| status_pull | output | 1 | 1 pulls the shared status line low |
| user_mode | output | 1 | High once the device has entered user mode |
| byte_out | output | DATA_W | Most recently assembled configuration byte |
| byte_valid | output | 1 | One-cycle strobe marking a new byte_out |

## Verification
The bench sweeps many byte patterns through both modes, with junk on the unused data lines in serial mode. A packer that ran most significant bit first, or that read the wrong line, would give the wrong bytes. Every cycle of a load is checked for the hand-off. A counter that had an off-by-one error or counted bytes as bits would release one cycle early, one cycle late, or never. User-mode entry is checked with another device still holding done low, which catches a device that starts before its neighbours. Restarts are forced both by withdrawing the enable mid-load and by an external status pull after release, and each is followed by a full reload. A block that kept its count across a restart would hand off early on the reload.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_LOAD     = 2'd1,
    ST_RELEASED = 2'd2,
    ST_USER     = 2'd3
  } rx_state_t;
endpackage

// File: rtl/cfg_rx_assembler.sv
module cfg_rx_assembler #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cap,
  input  logic              par_mode,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_valid
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] shifted;

  // new serial bit enters at the top, so the first bit ends up at bit 0
  assign shifted = {din[0], shreg[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shreg      <= '0;
      bidx       <= '0;
      byte_valid <= 1'b0;
      byte_out   <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (cap) begin
        if (par_mode) begin
          byte_out   <= din;
          byte_valid <= 1'b1;
        end else begin
          shreg <= shifted;
          bidx  <= bidx + 1'b1;
          if (bidx == LAST_BIT) begin
            byte_out   <= shifted;
            byte_valid <= 1'b1;
          end
        end
      end
    end
  end

  // R2: no byte appears unless a unit was captured on the edge before
  assert_no_strobe_without_capture_R2: assert property (@(posedge clk) disable iff (rst)
    !cap |=> !byte_valid);
endmodule

// File: rtl/cfg_rx_counter.sv
module cfg_rx_counter #(
  parameter int CFG_BITS = 64,
  parameter int DATA_W   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic par_mode,
  output logic last
);
  localparam int CW = $clog2(CFG_BITS + 1);
  localparam int UNITS_PAR = CFG_BITS / DATA_W;

  logic [CW-1:0] count;
  logic [CW-1:0] target;

  assign target = par_mode ? CW'(UNITS_PAR) : CW'(CFG_BITS);
  assign last   = (count == target - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  // R5: the count never runs past the full serial length
  assert_count_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(CFG_BITS));
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx
  import cfg_chain_pkg::*;
#(
  parameter int CFG_BITS = 64,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_mode,
  input  logic              chip_en_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic              done_wired,
  input  logic              status_wired,
  output logic              chain_en_n,
  output logic              done_pull,
  output logic              status_pull,
  output logic              user_mode,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_valid
);
  rx_state_t state;
  logic cap, last, restart;

  assign restart = !status_wired && (state != ST_USER);
  assign cap = ((state == ST_IDLE) || (state == ST_LOAD)) && !chip_en_n && status_wired;

  cfg_rx_counter #(.CFG_BITS(CFG_BITS), .DATA_W(DATA_W)) u_count (
    .clk(clk), .rst(rst), .clr(restart), .inc(cap), .par_mode(par_mode), .last(last)
  );

  cfg_rx_assembler #(.DATA_W(DATA_W)) u_asm (
    .clk(clk), .rst(rst), .clr(restart), .cap(cap), .par_mode(par_mode),
    .din(data_in), .byte_out(byte_out), .byte_valid(byte_valid)
  );

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      state       <= ST_IDLE;
      chain_en_n  <= 1'b1;
      done_pull   <= 1'b1;
      status_pull <= 1'b0;
      user_mode   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cap) begin
            if (last) begin
              state      <= ST_RELEASED;
              chain_en_n <= 1'b0;
              done_pull  <= 1'b0;
            end else begin
              state <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (chip_en_n) begin
            status_pull <= 1'b1;
            state       <= ST_IDLE;
          end else if (cap && last) begin
            state      <= ST_RELEASED;
            chain_en_n <= 1'b0;
            done_pull  <= 1'b0;
          end
        end
        ST_RELEASED: begin
          if (done_wired) begin
            state     <= ST_USER;
            user_mode <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R6: the next device is never enabled while this one still holds done low
  assert_handoff_releases_done_R6: assert property (@(posedge clk) disable iff (rst)
    !chain_en_n |-> !done_pull);

  // R7: user mode begins only after the shared done line read high
  assert_user_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(user_mode) |-> $past(done_wired));

  // R8: an error pull lasts a single cycle
  assert_error_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    status_pull |=> !status_pull);

  // R9: a low status outside user mode returns the block to its idle outputs
  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (!status_wired && !user_mode) |=> (chain_en_n && done_pull && !status_pull));
endmodule

// File: tb/cfg_chain_rx_bench.sv
module cfg_chain_rx_bench;
  localparam int BITS = 16;
  localparam int W    = 8;

  logic clk = 1'b0;
  logic rst, par_mode, chip_en_n, ext_done_pull, ext_status_pull;
  logic [W-1:0] data_in;
  logic done_wired, status_wired;
  logic chain_en_n, done_pull, status_pull, user_mode, byte_valid;
  logic [W-1:0] byte_out;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign done_wired   = !(done_pull || ext_done_pull);
  assign status_wired = !(status_pull || ext_status_pull);

  cfg_chain_rx #(.CFG_BITS(BITS), .DATA_W(W)) u_cfg_chain_rx (
    .clk(clk), .rst(rst), .par_mode(par_mode), .chip_en_n(chip_en_n),
    .data_in(data_in), .done_wired(done_wired), .status_wired(status_wired),
    .chain_en_n(chain_en_n), .done_pull(done_pull), .status_pull(status_pull),
    .user_mode(user_mode), .byte_out(byte_out), .byte_valid(byte_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1; chip_en_n = 1'b1; ext_done_pull = 1'b0; ext_status_pull = 1'b0;
    data_in = '0;
    tick();
    rst = 1'b0;
    check("R1 chain", chain_en_n, 1);
    check("R1 done", done_pull, 1);
    check("R1 status", status_pull, 0);
    check("R1 user", user_mode, 0);
    check("R1 valid", byte_valid, 0);
  endtask

  // full load of two bytes; ext_done_pull held so the block waits after release
  task automatic load(input logic mode, input logic [7:0] b0, input logic [7:0] b1);
    logic [7:0] bytes [2];
    int n;
    bytes[0] = b0; bytes[1] = b1;
    par_mode = mode;
    n = mode ? BITS / W : BITS;
    ext_done_pull = 1'b1;
    chip_en_n = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (mode) data_in = bytes[k];
      else data_in = {7'(k * 13 + 1), bytes[k / 8][k % 8]};
      tick();
      if (mode) begin
        check("R4 valid", byte_valid, 1);
        check("R4 byte", byte_out, bytes[k]);
      end else begin
        check("R3 valid", byte_valid, (k % 8 == 7) ? 1 : 0);
        if (k % 8 == 7) check("R3 byte", byte_out, bytes[k / 8]);
      end
      check("R5 handoff", chain_en_n, (k == n - 1) ? 0 : 1);
      check("R6 done", done_pull, (k == n - 1) ? 0 : 1);
    end
    chip_en_n = 1'b1;
    data_in = 8'hA5;
    tick();
    check("R5 hold", chain_en_n, 0);
  endtask

  task automatic enter_user();
    tick();
    check("R7 wait", user_mode, 0);
    ext_done_pull = 1'b0;
    tick();
    check("R7 user", user_mode, 1);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    par_mode = 1'b0;
    for (int p = 0; p < 8; p++) begin
      do_reset();
      for (int j = 0; j < 3; j++) begin
        data_in = 8'(p * 29 + j);
        tick();
        check("R2 valid", byte_valid, 0);
        check("R2 chain", chain_en_n, 1);
      end
      load(1'b0, 8'(p * 37 + 5), ~8'(p * 59));
      enter_user();
      do_reset();
      load(1'b1, 8'(p * 71 + 3), 8'(p * 17 + 200));
      enter_user();
      // R10: user mode ignores data, enable and status
      chip_en_n = 1'b0; data_in = 8'hFF; ext_status_pull = 1'b1;
      tick();
      tick();
      check("R10 valid", byte_valid, 0);
      check("R10 user", user_mode, 1);
      ext_status_pull = 1'b0;
    end

    // R8 / R9: enable withdrawn mid-load, then a full reload
    do_reset();
    par_mode = 1'b0; chip_en_n = 1'b0;
    for (int k = 0; k < 5; k++) begin data_in = 8'(k & 1); tick(); end
    chip_en_n = 1'b1;
    tick();
    check("R8 pull", status_pull, 1);
    tick();
    check("R8 one cycle", status_pull, 0);
    check("R9 chain", chain_en_n, 1);
    check("R9 done", done_pull, 1);
    load(1'b0, 8'h3C, 8'hC1);
    enter_user();

    // R9: external status pull after release
    do_reset();
    load(1'b1, 8'h12, 8'h34);
    ext_status_pull = 1'b1;
    tick();
    check("R9 ext chain", chain_en_n, 1);
    check("R9 ext done", done_pull, 1);
    check("R9 ext user", user_mode, 0);
    ext_status_pull = 1'b0;
    tick();
    load(1'b1, 8'h56, 8'h78);
    enter_user();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule